// File: doc/BRIEF.md
# Quad Wiper Register Bank Controller

This block keeps the digital state of four potentiometer channels. Each channel owns a live 6-bit wiper register that picks one of 64 taps, and four stored presets that model persistent memory. A single decoded command port reads or writes the wiper or a preset, and copies a value between a preset and the wiper in either direction. The serial front end that decodes these commands and the analog resistor array that the tap select drives sit outside this block.

Preset contents survive a synchronous reset. While reset is high, each wiper is reloaded from its preset 0. A store into a preset models a slow persistent write: it opens a busy window of `BUSY_CYC` cycles. During that window every command is refused with a busy reply. A hardware protect input, active low, blocks every store into a preset. It does not block moves into the wiper register.

Top module: `wbank_ctrl`

## Requirements
- R1: While `rst` is high, each channel's wiper is loaded from its preset 0. Preset contents are not altered by reset. After reset, `rd_valid`, `cmd_busy` and `nv_busy` are 0. Presets power up at 0.
- R2: `tap_sel[c*64 +: 64]` is one-hot, with the set bit at the index equal to channel c's wiper. It changes one cycle after the wiper changes.
- R3: Opcode 1 (write wiper) sets the addressed wiper to `cmd_data` on the accepting edge. It does not start a busy window, and it works whatever the level of `wp_n`.
- R4: Opcode 0 (read wiper) and opcode 2 (read preset `cmd_reg`) each give a one-cycle `rd_valid` pulse on the edge that accepts the command. `rd_data` carries the value held before that edge.
- R5: Opcode 3 (write preset) stores `cmd_data` into preset `cmd_reg` of channel `cmd_ch` when `wp_n` is 1.
- R6: Opcode 4 copies preset `cmd_reg` into the wiper. It is allowed while `wp_n` is 0 and starts no busy window.
- R7: Opcode 5 copies the wiper into preset `cmd_reg` when `wp_n` is 1.
- R8: While `wp_n` is 0, opcodes 3 and 5 leave every preset unchanged and start no busy window.
- R9: An accepted opcode 3 or 5 holds `nv_busy` high for the next `BUSY_CYC` cycles. A command presented during that window changes no state and gets no read reply. It is answered with a one-cycle `cmd_busy` pulse.
- R10: Opcodes 6 and 7 change no wiper, no preset and no output.
- R11: A command changes only the channel named by `cmd_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; triggers the preset 0 recall |
| wp_n | input | 1 | Preset write protect, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 0 read wiper, 1 write wiper, 2 read preset, 3 write preset, 4 preset to wiper, 5 wiper to preset |
| cmd_ch | input | 2 | Channel select |
| cmd_reg | input | 2 | Preset index |
| cmd_data | input | 6 | Write data |
| rd_valid | output | 1 | Read reply strobe |
| rd_data | output | 6 | Read reply data |
| cmd_busy | output | 1 | Command refused because a preset write is in progress |
| nv_busy | output | 1 | Preset write window active |
| tap_sel | output | 256 | One-hot tap select, 64 bits per channel, channel 0 in the low bits |

## Verification
The assertions check several properties on every cycle: the tap selects stay one-hot, no preset moves in a cycle after protect was low, and the wiper sits on preset 0 when reset ends. They also check that a command arriving during the busy window is answered busy and never read, and that a protected store opens no window. Only the bench scenarios can show that the values landing in wipers and presets are the right ones. The same holds for the exact length of the busy window, which is checked by the first command it accepts again, and for presets surviving a reset while the wipers pick up preset 0.

// File: rtl/wbank_pkg.sv
package wbank_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_RD_WIPER    = 3'd0,
    OP_WR_WIPER    = 3'd1,
    OP_RD_PRESET   = 3'd2,
    OP_WR_PRESET   = 3'd3,
    OP_LOAD_WIPER  = 3'd4,
    OP_STORE_WIPER = 3'd5
  } op_e;
endpackage

// File: rtl/wbank_nvtimer.sv
module wbank_nvtimer #(
  parameter int BUSY_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (start)
      cnt_q <= CNT_W'(BUSY_CYC);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(BUSY_CYC)); // R9
  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R9
endmodule

// File: rtl/wbank_chan.sv
module wbank_chan
  import wbank_pkg::*;
#(
  parameter int TAP_W = 6,
  parameter int N_DR  = 4,
  localparam int TAPS  = 1 << TAP_W,
  localparam int IDX_W = $clog2(N_DR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wp_n,
  input  logic             hit,
  input  logic [OP_W-1:0]  op,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAP_W-1:0] din,
  output logic [TAP_W-1:0] wcr_o,
  output logic [TAP_W-1:0] dr_o,
  output logic [TAPS-1:0]  tap_o
);
  logic [TAP_W-1:0] dr_mem [N_DR] = '{default: '0};
  logic [TAP_W-1:0] wcr_q;
  logic [TAPS-1:0]  tap_q;
  logic             nv_wr;
  logic [TAP_W-1:0] nv_val;

  assign nv_wr  = hit && wp_n && (op == OP_WR_PRESET || op == OP_STORE_WIPER);
  assign nv_val = (op == OP_STORE_WIPER) ? wcr_q : din;

  // preset store, no reset so contents persist across rst
  always_ff @(posedge clk) begin
    if (nv_wr)
      dr_mem[idx] <= nv_val;
  end

  always_ff @(posedge clk) begin
    if (rst)
      wcr_q <= dr_mem[0];
    else if (hit) begin
      if (op == OP_WR_WIPER)
        wcr_q <= din;
      else if (op == OP_LOAD_WIPER)
        wcr_q <= dr_mem[idx];
    end
  end

  always_ff @(posedge clk) begin
    tap_q <= {{(TAPS-1){1'b0}}, 1'b1} << wcr_q;
  end

  assign wcr_o = wcr_q;
  assign dr_o  = dr_mem[idx];
  assign tap_o = tap_q;

  logic [N_DR*TAP_W-1:0] dr_view;
  for (genvar i = 0; i < N_DR; i++) begin : g_view
    assign dr_view[i*TAP_W +: TAP_W] = dr_mem[i];
  end

  AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(tap_q)); // R2
  AST_WP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wp_n |=> $stable(dr_view)); // R8
  AST_RECALL: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (wcr_q == dr_mem[0])); // R1
  AST_IDLE_WIPER: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(wcr_q)); // R11
endmodule

// File: rtl/wbank_ctrl.sv
module wbank_ctrl
  import wbank_pkg::*;
#(
  parameter int N_CH     = 4,
  parameter int N_DR     = 4,
  parameter int TAP_W    = 6,
  parameter int BUSY_CYC = 8,
  localparam int CH_W  = $clog2(N_CH),
  localparam int IDX_W = $clog2(N_DR),
  localparam int TAPS  = 1 << TAP_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wp_n,
  input  logic                 cmd_valid,
  input  logic [OP_W-1:0]      cmd_op,
  input  logic [CH_W-1:0]      cmd_ch,
  input  logic [IDX_W-1:0]     cmd_reg,
  input  logic [TAP_W-1:0]     cmd_data,
  output logic                 rd_valid,
  output logic [TAP_W-1:0]     rd_data,
  output logic                 cmd_busy,
  output logic                 nv_busy,
  output logic [N_CH*TAPS-1:0] tap_sel
);
  logic             busy;
  logic             accept;
  logic             nv_start;
  logic             is_read;
  logic [TAP_W-1:0] wcr_all [N_CH];
  logic [TAP_W-1:0] dr_all  [N_CH];

  assign accept   = cmd_valid && !rst && !busy;
  assign nv_start = accept && wp_n &&
                    (cmd_op == OP_WR_PRESET || cmd_op == OP_STORE_WIPER);
  assign is_read  = (cmd_op == OP_RD_WIPER) || (cmd_op == OP_RD_PRESET);

  wbank_nvtimer #(.BUSY_CYC(BUSY_CYC)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (nv_start),
    .busy  (busy)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    wbank_chan #(.TAP_W(TAP_W), .N_DR(N_DR)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .wp_n  (wp_n),
      .hit   (accept && (cmd_ch == CH_W'(c))),
      .op    (cmd_op),
      .idx   (cmd_reg),
      .din   (cmd_data),
      .wcr_o (wcr_all[c]),
      .dr_o  (dr_all[c]),
      .tap_o (tap_sel[c*TAPS +: TAPS])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      cmd_busy <= 1'b0;
    end else begin
      rd_valid <= accept && is_read;
      cmd_busy <= cmd_valid && busy;
      if (accept && is_read)
        rd_data <= (cmd_op == OP_RD_WIPER) ? wcr_all[cmd_ch] : dr_all[cmd_ch];
    end
  end

  assign nv_busy = busy;

  AST_BUSY_REPLY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && nv_busy) |=> (cmd_busy && !rd_valid)); // R9
  AST_WIPER_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !nv_busy && cmd_op == OP_WR_WIPER) |=> (!nv_busy && !rd_valid && !cmd_busy)); // R3
  AST_WP_NO_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (!nv_busy && !wp_n) |=> !nv_busy); // R8
  AST_READ_REPLY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !nv_busy && (cmd_op == OP_RD_WIPER || cmd_op == OP_RD_PRESET)) |=> rd_valid); // R4
endmodule

// File: tb/wbank_ctrl_test.sv
`timescale 1ns/1ps
module wbank_ctrl_test;
  localparam int BUSY = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wp_n = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_op = '0;
  logic [1:0]   cmd_ch = '0;
  logic [1:0]   cmd_reg = '0;
  logic [5:0]   cmd_data = '0;
  logic         rd_valid;
  logic [5:0]   rd_data;
  logic         cmd_busy;
  logic         nv_busy;
  logic [255:0] tap_sel;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [5:0] m_wcr [4];
  logic [5:0] m_dr  [4][4];

  always #2.5 clk = ~clk;

  wbank_ctrl #(.BUSY_CYC(BUSY)) uut (
    .clk(clk), .rst(rst), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_ch(cmd_ch), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .cmd_busy(cmd_busy),
    .nv_busy(nv_busy), .tap_sel(tap_sel)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] exp_taps();
    logic [255:0] v = '0;
    for (int c = 0; c < 4; c++) v[c*64 + int'(m_wcr[c])] = 1'b1;
    return v;
  endfunction

  // drive at negedge, return at the negedge after the accepting edge
  task automatic issue(input logic [2:0] op, input int ch, input int rg, input logic [5:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_ch = 2'(ch); cmd_reg = 2'(rg); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(4);
    rst = 1'b0;
    for (int c = 0; c < 4; c++) m_wcr[c] = m_dr[c][0];
    idle(1);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) for (int r = 0; r < 4; r++) m_dr[c][r] = '0;
    @(negedge clk);
    do_reset();
    // R1 R2: power-up presets are 0, so taps sit on bit 0
    chk(!rd_valid && !cmd_busy && !nv_busy, "R1 idle outputs", {rd_valid, cmd_busy, nv_busy}, 0);
    chk(tap_sel == exp_taps(), "R1 R2 reset taps", tap_sel, exp_taps());

    // R2 R3 R11: sweep every tap on every channel
    for (int c = 0; c < 4; c++) begin
      for (int v = 0; v < 64; v++) begin
        issue(3'd1, c, 0, 6'(v));
        m_wcr[c] = 6'(v);
        chk(!cmd_busy && !nv_busy && !rd_valid, "R3 wiper write no busy", {cmd_busy, nv_busy}, 0);
        @(negedge clk);
        chk(tap_sel == exp_taps(), "R2 R11 tap select", tap_sel, exp_taps());
      end
      issue(3'd0, c, 0, 6'd0);
      chk(rd_valid && rd_data == m_wcr[c], "R4 read wiper", rd_data, m_wcr[c]);
    end

    // R5 R9: write all presets, waiting out each window
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        logic [5:0] val = 6'((c * 16 + r * 5 + 7) % 64);
        issue(3'd3, c, r, val);
        m_dr[c][r] = val;
        chk(nv_busy, "R9 window opens", nv_busy, 1);
        idle(BUSY);
        chk(!nv_busy, "R9 window closes", nv_busy, 0);
      end
    end
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        issue(3'd2, c, r, 6'd0);
        chk(rd_valid && rd_data == m_dr[c][r], "R4 R5 read preset", rd_data, m_dr[c][r]);
      end
    end

    // R9: every command inside the window is refused, the next one is served
    issue(3'd3, 0, 1, 6'd44);
    m_dr[0][1] = 6'd44;
    for (int j = 0; j < BUSY; j++) begin
      issue(3'd1, 0, 0, 6'd33);
      chk(cmd_busy && !rd_valid, "R9 refused in window", {cmd_busy, rd_valid}, 2'b10);
    end
    issue(3'd0, 0, 0, 6'd0);
    chk(rd_valid && !cmd_busy && rd_data == m_wcr[0], "R9 first accepted after window", rd_data, m_wcr[0]);

    // R1: reset recalls preset 0, presets persist
    do_reset();
    chk(tap_sel == exp_taps(), "R1 R2 recall taps", tap_sel, exp_taps());
    for (int c = 0; c < 4; c++) begin
      issue(3'd0, c, 0, 6'd0);
      chk(rd_valid && rd_data == m_dr[c][0], "R1 wiper recall", rd_data, m_dr[c][0]);
      issue(3'd2, c, 2, 6'd0);
      chk(rd_data == m_dr[c][2], "R1 preset persists", rd_data, m_dr[c][2]);
    end

    // R8: protect blocks preset stores
    wp_n = 1'b0;
    issue(3'd3, 2, 3, 6'd9);
    chk(!nv_busy, "R8 no window on protected write", nv_busy, 0);
    issue(3'd2, 2, 3, 6'd0);
    chk(rd_data == m_dr[2][3], "R8 protected write ignored", rd_data, m_dr[2][3]);
    issue(3'd5, 1, 0, 6'd0);
    chk(!nv_busy, "R8 no window on protected store", nv_busy, 0);
    issue(3'd2, 1, 0, 6'd0);
    chk(rd_data == m_dr[1][0], "R8 protected store ignored", rd_data, m_dr[1][0]);
    // R3: wiper write allowed under protect
    issue(3'd1, 3, 0, 6'd50);
    m_wcr[3] = 6'd50;
    issue(3'd0, 3, 0, 6'd0);
    chk(rd_data == 6'd50, "R3 wiper write under protect", rd_data, 50);
    // R6: preset to wiper under protect
    issue(3'd4, 2, 1, 6'd0);
    m_wcr[2] = m_dr[2][1];
    chk(!nv_busy, "R6 no window", nv_busy, 0);
    @(negedge clk);
    chk(tap_sel == exp_taps(), "R6 R2 load taps", tap_sel, exp_taps());
    issue(3'd0, 2, 0, 6'd0);
    chk(rd_data == m_dr[2][1], "R6 load wiper", rd_data, m_dr[2][1]);

    // R7: wiper to preset
    wp_n = 1'b1;
    issue(3'd1, 1, 0, 6'd17);
    m_wcr[1] = 6'd17;
    issue(3'd5, 1, 2, 6'd0);
    m_dr[1][2] = 6'd17;
    chk(nv_busy, "R7 store opens window", nv_busy, 1);
    idle(BUSY);
    issue(3'd2, 1, 2, 6'd0);
    chk(rd_valid && rd_data == 6'd17, "R7 store wiper", rd_data, 17);

    // R10: undefined opcodes do nothing
    issue(3'd6, 0, 0, 6'd63);
    chk(!nv_busy && !rd_valid && !cmd_busy, "R10 op6 quiet", {nv_busy, rd_valid, cmd_busy}, 0);
    issue(3'd7, 0, 0, 6'd63);
    chk(!nv_busy && !rd_valid && !cmd_busy, "R10 op7 quiet", {nv_busy, rd_valid, cmd_busy}, 0);
    @(negedge clk);
    chk(tap_sel == exp_taps(), "R10 taps unchanged", tap_sel, exp_taps());
    for (int r = 0; r < 4; r++) begin
      issue(3'd2, 0, r, 6'd0);
      chk(rd_data == m_dr[0][r], "R10 presets unchanged", rd_data, m_dr[0][r]);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule